// File: doc/BRIEF.md
# Stack and Control-Transfer Sequencer

This block owns a processor's program counter and stack pointer and carries out the instructions that move them: push, pop, subroutine call, subroutine return, return from interrupt, absolute branch, relative conditional jump and a plain program-counter advance. Each operation is requested by a one-cycle start pulse that carries an operation code, a source value, a 10-bit word offset, a condition code and an instruction length. When the operation is complete, the block answers with a one-cycle done pulse. The stack is made of 16-bit words and grows downward. A push or call first lowers the stack pointer and then writes. A pop or return first reads and then raises the stack pointer.

The block drives a single-port synchronous data memory with byte addresses. Each access is a whole word, so the address is always even. Read data comes back in the cycle after the address is presented. The status flags carry, zero, negative and overflow come from outside and are used only for jump decisions. A return from interrupt reads the saved status word first and then the program counter. It hands the status word back on a separate output, marked by a load pulse. Instruction fetch, decoding and the ALU live elsewhere.

Top module: `stack_ctl_seq`

## Requirements
- R1: After reset, pc is 0xC000, sp is 0x0280, and done, busy and sr_load are 0.
- R2: Push (op 0) lowers sp by 2 and then writes src to memory at the new sp. Done rises one cycle after the accepting edge.
- R3: Pop (op 1) reads the word at sp onto pop_data and then raises sp by 2. Done rises two cycles after the accepting edge.
- R4: Call (op 2) lowers sp by 2, stores the current pc at the new sp, and then loads pc with src. Done rises one cycle after the accepting edge.
- R5: Return (op 3) loads pc from the word at sp and raises sp by 2. Done rises two cycles after the accepting edge.
- R6: Return from interrupt (op 4) first pops the status word onto sr_out and then pops pc, raising sp by 4 in total. Done and sr_load pulse together four cycles after the accepting edge.
- R7: Bit 0 of pc is always 0. Any value loaded into pc by branch, call, return or return from interrupt has bit 0 cleared. sp stays even.
- R8: A conditional jump (op 6) selects its condition with jmp_cond: 0 = Z clear, 1 = Z set, 2 = C clear, 3 = C set, 4 = N set, 5 = N xor V is 0, 6 = N xor V is 1, 7 = always. A taken jump sets pc to pc + 2*sign-extended jmp_off. A jump that is not taken leaves pc unchanged. Done rises on the accepting edge.
- R9: Advance (op 7) adds 2*ilen to pc, where ilen is 1, 2 or 3 words. Branch (op 5) loads pc with src. Both complete on the accepting edge.
- R10: A start that arrives while busy is ignored. pc and sp show no trace of it, and no extra done pulse follows.
- R11: sp moves only in steps of 2. pc changes only on the edge that raises done. A memory write is always followed by done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operation request, accepted only when idle |
| op | input | 3 | Operation code |
| src | input | 16 | Push data, call target or branch target |
| jmp_off | input | 10 | Signed word offset for conditional jumps |
| jmp_cond | input | 3 | Jump condition select |
| ilen | input | 2 | Instruction length in words for advance |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Signed overflow flag |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory byte address, always even |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid the cycle after the address |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Multi-cycle operation in progress |
| sr_load | output | 1 | Restored status word is valid (with done) |
| sr_out | output | 16 | Status word popped by return from interrupt |
| pop_data | output | 16 | Word popped by the last pop |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |

## Verification
Branch, advance and conditional jumps raise done on the edge that accepts the start. Push and call take one more edge, pop and return take two more, and return from interrupt takes four more. Every scenario task drives start on a falling edge, counts falling edges until it sees done, and compares that count with the latency its requirement fixes. The bench samples pc, sp, pop_data, sr_out and the bench memory on that same falling edge. For the ignored-start case, a start pulse is placed inside a push's busy cycle, and the bench checks at the next two falling edges that done appears exactly once and that pc is unchanged.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;
    typedef enum logic [2:0] {
        OP_PUSH = 3'd0,
        OP_POP  = 3'd1,
        OP_CALL = 3'd2,
        OP_RET  = 3'd3,
        OP_RETI = 3'd4,
        OP_BR   = 3'd5,
        OP_JCC  = 3'd6,
        OP_ADV  = 3'd7
    } stk_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WR   = 2'd1,
        ST_RD   = 2'd2,
        ST_CAP  = 2'd3
    } stk_st_e;
endpackage

// File: rtl/stk_cond_eval.sv
module stk_cond_eval (
    input  logic [2:0] cond,
    input  logic       fc,
    input  logic       fz,
    input  logic       fn,
    input  logic       fv,
    output logic       take
);
    always_comb begin
        case (cond)
            3'd0:    take = ~fz;
            3'd1:    take = fz;
            3'd2:    take = ~fc;
            3'd3:    take = fc;
            3'd4:    take = fn;
            3'd5:    take = ~(fn ^ fv);
            3'd6:    take = fn ^ fv;
            default: take = 1'b1;
        endcase
    end
endmodule

// File: rtl/stk_jmp_target.sv
module stk_jmp_target #(
    parameter int W    = 16,
    parameter int OFFW = 10
) (
    input  logic [W-1:0]    base,
    input  logic [OFFW-1:0] off,
    output logic [W-1:0]    target
);
    logic [W-1:0] ext;

    always_comb begin
        ext    = {{(W-OFFW){off[OFFW-1]}}, off};
        target = base + {ext[W-2:0], 1'b0};
    end
endmodule

// File: rtl/stack_ctl_seq.sv
module stack_ctl_seq
    import stk_seq_pkg::*;
#(
    parameter int          W        = 16,
    parameter int          OFFW     = 10,
    parameter logic [15:0] PC_RESET = 16'hC000,
    parameter logic [15:0] SP_RESET = 16'h0280
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      op,
    input  logic [W-1:0]    src,
    input  logic [OFFW-1:0] jmp_off,
    input  logic [2:0]      jmp_cond,
    input  logic [1:0]      ilen,
    input  logic            flag_c,
    input  logic            flag_z,
    input  logic            flag_n,
    input  logic            flag_v,
    output logic            mem_en,
    output logic            mem_we,
    output logic [W-1:0]    mem_addr,
    output logic [W-1:0]    mem_wdata,
    input  logic [W-1:0]    mem_rdata,
    output logic            done,
    output logic            busy,
    output logic            sr_load,
    output logic [W-1:0]    sr_out,
    output logic [W-1:0]    pop_data,
    output logic [W-1:0]    pc,
    output logic [W-1:0]    sp
);
    localparam logic [W-1:0] STEP      = W'(W / 8);
    localparam logic [W-1:0] EVEN_MASK = {{(W-1){1'b1}}, 1'b0};

    typedef struct packed {
        stk_st_e      st;
        stk_op_e      op;
        logic         second;
        logic [W-1:0] pc;
        logic [W-1:0] sp;
        logic [W-1:0] hold;
        logic [W-1:0] pop;
        logic [W-1:0] sr;
        logic         done;
        logic         srld;
    } seq_t;

    seq_t         q, d;
    logic         take;
    logic [W-1:0] jtarget;

    stk_cond_eval u_cond (
        .cond (jmp_cond),
        .fc   (flag_c),
        .fz   (flag_z),
        .fn   (flag_n),
        .fv   (flag_v),
        .take (take)
    );

    stk_jmp_target #(.W(W), .OFFW(OFFW)) u_tgt (
        .base   (q.pc),
        .off    (jmp_off),
        .target (jtarget)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.srld    = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.sp;
        mem_wdata = (q.op == OP_CALL) ? q.pc : q.hold;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.op     = stk_op_e'(op);
                    d.second = 1'b0;
                    case (stk_op_e'(op))
                        OP_PUSH, OP_CALL: begin
                            d.sp   = q.sp - STEP;
                            d.hold = src;
                            d.st   = ST_WR;
                        end
                        OP_POP, OP_RET, OP_RETI: d.st = ST_RD;
                        OP_BR: begin
                            d.pc   = src & EVEN_MASK;
                            d.done = 1'b1;
                        end
                        OP_JCC: begin
                            if (take) d.pc = jtarget & EVEN_MASK;
                            d.done = 1'b1;
                        end
                        default: begin
                            d.pc   = q.pc + W'({ilen, 1'b0});
                            d.done = 1'b1;
                        end
                    endcase
                end
            end
            ST_WR: begin
                mem_en = 1'b1;
                mem_we = 1'b1;
                if (q.op == OP_CALL) d.pc = q.hold & EVEN_MASK;
                d.st   = ST_IDLE;
                d.done = 1'b1;
            end
            ST_RD: begin
                mem_en = 1'b1;
                d.st   = ST_CAP;
            end
            default: begin
                d.sp = q.sp + STEP;
                if (q.op == OP_POP) begin
                    d.pop  = mem_rdata;
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end else if (q.op == OP_RETI && !q.second) begin
                    d.sr     = mem_rdata;
                    d.second = 1'b1;
                    d.st     = ST_RD;
                end else begin
                    d.pc   = mem_rdata & EVEN_MASK;
                    d.srld = (q.op == OP_RETI);
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st     <= ST_IDLE;
            q.op     <= OP_PUSH;
            q.second <= 1'b0;
            q.pc     <= W'(PC_RESET);
            q.sp     <= W'(SP_RESET);
            q.hold   <= '0;
            q.pop    <= '0;
            q.sr     <= '0;
            q.done   <= 1'b0;
            q.srld   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign done     = q.done;
    assign busy     = (q.st != ST_IDLE);
    assign sr_load  = q.srld;
    assign sr_out   = q.sr;
    assign pop_data = q.pop;
    assign pc       = q.pc;
    assign sp       = q.sp;
endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         done,
    input logic         mem_we,
    input logic [W-1:0] pc,
    input logic [W-1:0] sp
);
    // R7: program counter never odd
    a_r7_pc_even: assert property (@(posedge clk) disable iff (!rst_n) !pc[0]);

    // R7: stack pointer never odd
    a_r7_sp_even: assert property (@(posedge clk) disable iff (!rst_n) !sp[0]);

    // R2: a write lands after the stack pointer has been lowered
    a_r2_write_after_dec: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> sp == $past(sp) - W'(2));

    // R11: stack pointer moves only by one word
    a_r11_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sp) |-> (sp == $past(sp) + W'(2)) || (sp == $past(sp) - W'(2)));

    // R11: program counter changes only together with done
    a_r11_pc_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc) |-> done);

    // R11: a memory write completes the operation
    a_r11_we_done: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> done);
endmodule

bind stack_ctl_seq stk_seq_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (done),
    .mem_we (mem_we),
    .pc     (pc),
    .sp     (sp)
);

// File: tb/stack_ctl_seq_bench.sv
module stack_ctl_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [15:0] src = 16'h0;
    logic [9:0]  jmp_off = 10'h0;
    logic [2:0]  jmp_cond = 3'd0;
    logic [1:0]  ilen = 2'd0;
    logic        flag_c = 1'b0, flag_z = 1'b0, flag_n = 1'b0, flag_v = 1'b0;
    logic        mem_en, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = 16'h0;
    logic        done, busy, sr_load;
    logic [15:0] sr_out, pop_data, pc, sp;
    logic [15:0] ram [0:255];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    always_ff @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) ram[mem_addr[8:1]] <= mem_wdata;
            else        mem_rdata <= ram[mem_addr[8:1]];
        end
    end

    stack_ctl_seq u_stack_ctl_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .src(src),
        .jmp_off(jmp_off), .jmp_cond(jmp_cond), .ilen(ilen),
        .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done),
        .busy(busy), .sr_load(sr_load), .sr_out(sr_out),
        .pop_data(pop_data), .pc(pc), .sp(sp)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] o, input logic [15:0] s, input logic [9:0] off,
                          input logic [2:0] cd, input logic [1:0] il, output int lat);
        @(negedge clk);
        op = o; src = s; jmp_off = off; jmp_cond = cd; ilen = il; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        if (!done) lat = -1;
    endtask

    task automatic t_reset();
        check("R1 pc", pc, 16'hC000);
        check("R1 sp", sp, 16'h0280);
        check("R1 done", {15'd0, done}, 16'd0);
        check("R1 busy", {15'd0, busy}, 16'd0);
        check("R1 sr_load", {15'd0, sr_load}, 16'd0);
    endtask

    task automatic t_branch_adv();
        int lat;
        run_op(3'd5, 16'h4001, 10'h0, 3'd0, 2'd0, lat);
        check("R9 branch latency", 16'(lat), 16'd1);
        check("R7 branch clears bit0", pc, 16'h4000);
        run_op(3'd7, 16'h0, 10'h0, 3'd0, 2'd3, lat);
        check("R9 advance 3 words", pc, 16'h4006);
        check("R9 advance latency", 16'(lat), 16'd1);
        run_op(3'd7, 16'h0, 10'h0, 3'd0, 2'd1, lat);
        check("R9 advance 1 word", pc, 16'h4008);
    endtask

    task automatic t_push_pop();
        int lat;
        run_op(3'd0, 16'hA55A, 10'h0, 3'd0, 2'd0, lat);
        check("R2 push latency", 16'(lat), 16'd2);
        check("R2 push sp", sp, 16'h027E);
        check("R2 push data", ram[8'h3F], 16'hA55A);
        run_op(3'd0, 16'h1234, 10'h0, 3'd0, 2'd0, lat);
        check("R2 second push sp", sp, 16'h027C);
        check("R2 second push data", ram[8'h3E], 16'h1234);
        run_op(3'd1, 16'h0, 10'h0, 3'd0, 2'd0, lat);
        check("R3 pop latency", 16'(lat), 16'd3);
        check("R3 pop data", pop_data, 16'h1234);
        check("R3 pop sp", sp, 16'h027E);
        check("R3 pop keeps pc", pc, 16'h4008);
    endtask

    task automatic t_call_ret();
        int lat;
        run_op(3'd2, 16'h5001, 10'h0, 3'd0, 2'd0, lat);
        check("R4 call latency", 16'(lat), 16'd2);
        check("R4 call sp", sp, 16'h027C);
        check("R4 call saved pc", ram[8'h3E], 16'h4008);
        check("R4 R7 call target", pc, 16'h5000);
        run_op(3'd3, 16'h0, 10'h0, 3'd0, 2'd0, lat);
        check("R5 ret latency", 16'(lat), 16'd3);
        check("R5 ret pc", pc, 16'h4008);
        check("R5 ret sp", sp, 16'h027E);
        run_op(3'd1, 16'h0, 10'h0, 3'd0, 2'd0, lat);
        check("R3 pop first word", pop_data, 16'hA55A);
        check("R3 pop back to top", sp, 16'h0280);
    endtask

    task automatic t_reti();
        int lat;
        run_op(3'd0, 16'h6003, 10'h0, 3'd0, 2'd0, lat);
        run_op(3'd0, 16'h0008, 10'h0, 3'd0, 2'd0, lat);
        check("R6 setup sp", sp, 16'h027C);
        run_op(3'd4, 16'h0, 10'h0, 3'd0, 2'd0, lat);
        check("R6 reti latency", 16'(lat), 16'd5);
        check("R6 sr_load with done", {15'd0, sr_load}, 16'd1);
        check("R6 restored sr", sr_out, 16'h0008);
        check("R6 R7 restored pc", pc, 16'h6002);
        check("R6 sp", sp, 16'h0280);
        @(negedge clk);
        check("R6 sr_load one cycle", {15'd0, sr_load}, 16'd0);
    endtask

    task automatic t_jumps();
        int lat;
        logic [15:0] base, expv, ext;
        bit tk;
        for (int cd = 0; cd < 8; cd++) begin
            for (int f = 0; f < 16; f++) begin
                @(negedge clk);
                {flag_c, flag_z, flag_n, flag_v} = 4'(f);
                base = pc;
                case (cd)
                    0: tk = !flag_z;
                    1: tk = flag_z;
                    2: tk = !flag_c;
                    3: tk = flag_c;
                    4: tk = flag_n;
                    5: tk = (flag_n == flag_v);
                    6: tk = (flag_n != flag_v);
                    default: tk = 1'b1;
                endcase
                ext  = (f % 2 == 0) ? 16'hFFF0 + 16'(f) : 16'h0010 + 16'(f);
                expv = tk ? base + (ext << 1) : base;
                run_op(3'd6, 16'h0, ext[9:0], 3'(cd), 2'd0, lat);
                check($sformatf("R8 jump cond %0d flags %0d", cd, f), pc, expv);
                check("R8 jump latency", 16'(lat), 16'd1);
            end
        end
    endtask

    task automatic t_busy_ignore();
        logic [15:0] pc0;
        pc0 = pc;
        @(negedge clk);
        op = 3'd0; src = 16'h7777; start = 1'b1;
        @(negedge clk);
        op = 3'd5; src = 16'h1234; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 push done", {15'd0, done}, 16'd1);
        check("R10 pc untouched", pc, pc0);
        check("R10 sp one push", sp, 16'h027E);
        @(negedge clk);
        check("R10 no extra done", {15'd0, done}, 16'd0);
        check("R10 pc still untouched", pc, pc0);
        check("R10 not busy", {15'd0, busy}, 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_branch_adv();
        t_push_pop();
        t_call_ret();
        t_reti();
        t_jumps();
        t_busy_ignore();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule